// File: doc/BRIEF.md
# Strobe-Clocked Flash Word Reader

This block gives a host a way to read one word at a time from a parallel flash device over four wires. The four wires are a serial address line from the host, a serial data line back to the host, and two active-low strobes. The block has no free-running clock. The two strobes are the only timing edges it has.

The mode strobe `mode_stb_n` has two jobs. Each rising edge on it moves one address bit into the address shifter, most significant bit first. The parallel value of that shifter drives the flash address bus at all times. The level of `mode_stb_n` also decides what a rising edge of the transfer strobe `xfer_stb_n` does:

- If `mode_stb_n` is high, the edge captures the whole flash data word.
- If `mode_stb_n` is low, the edge moves the captured word one place toward its least significant bit.

The return line always shows the current least significant bit of the word.

To read a word, the host first clocks in the address and holds `mode_stb_n` high. It then gives one capture pulse on `xfer_stb_n` and drops `mode_stb_n`. After that it samples the return line and pulses `xfer_stb_n`, repeating this once per bit. The host paces every transfer through the strobes, so there is no back-pressure path and no valid/ready pair.

Top module: `ppfr_bridge`

## Requirements
- R1: Each rising edge of `mode_stb_n` shifts `host_addr_bit` into the address shifter at bit 0, and the older bits move up one place. After ADDR_W such edges sent most significant bit first, `flash_addr` equals the address sent.
- R2: Edges of `xfer_stb_n` leave `flash_addr` unchanged.
- R3: A rising edge of `xfer_stb_n` while `mode_stb_n` is high (1) loads the full DATA_W-bit value on `flash_data` into the data word.
- R4: A rising edge of `xfer_stb_n` while `mode_stb_n` is low (0) shifts the data word right by one place. The value on `flash_data` at that edge has no effect on the word.
- R5: Each right shift puts a 0 into the most significant bit of the data word. After a load followed by DATA_W shifts, `host_data_bit` is 0.
- R6: `host_data_bit` is always bit 0 of the data word. A load followed by DATA_W shift pulses, with `host_data_bit` sampled before each pulse, returns the loaded word least significant bit first.
- R7: A high level on `rst` clears the address shifter and the data word to all zeros at once, with no strobe edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous reset, active high |
| host_addr_bit | input | 1 | Serial address bit from the host |
| mode_stb_n | input | 1 | Address clock strobe; its level selects load (1) or shift (0) |
| xfer_stb_n | input | 1 | Data strobe; its rising edge loads or shifts the data word |
| host_data_bit | output | 1 | Serial data bit to the host (bit 0 of the data word) |
| flash_addr | output | ADDR_W | Parallel address driven to the flash |
| flash_data | input | DATA_W | Parallel data word from the flash |

## Verification
The properties assume the following about the inputs:

- Both strobes are free of glitches.
- `mode_stb_n` is settled at every rising edge of `xfer_stb_n`.
- `flash_data` is stable around each capture edge.
- The two strobes never rise at the same instant.

The bench keeps to these rules by changing each input in its own half period, well away from any strobe edge. It uses random addresses and random flash contents, together with directed words that have isolated and adjacent set bits. It also changes the flash data in the middle of a shift-out and asserts reset in the middle of a read.

// File: rtl/ppfr_pkg.sv
package ppfr_pkg;

  // Meaning of the mode strobe level at a transfer strobe edge.
  typedef enum logic {
    XFER_SHIFT = 1'b0,
    XFER_LOAD  = 1'b1
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic mode_level);
    return (mode_level == 1'b1) ? XFER_LOAD : XFER_SHIFT;
  endfunction

endpackage

// File: rtl/ppfr_addr_shifter.sv
module ppfr_addr_shifter #(
  parameter int ADDR_W = 20
) (
  input  logic              rst,
  input  logic              stb_n,
  input  logic              bit_in,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  // Serial in, most significant bit first: new bits enter at bit 0.
  always_ff @(posedge stb_n or posedge rst) begin
    if (rst) addr_q <= '0;
    else     addr_q <= {addr_q[ADDR_W-2:0], bit_in};
  end

  assign addr = addr_q;
endmodule

// File: rtl/ppfr_word_shifter.sv
module ppfr_word_shifter
  import ppfr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              rst,
  input  logic              stb_n,
  input  logic              mode_level,
  input  logic [DATA_W-1:0] par_in,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nxt;
  xfer_mode_e        mode;

  assign mode = decode_mode(mode_level);

  always_comb begin
    unique case (mode)
      XFER_LOAD:  word_nxt = par_in;
      XFER_SHIFT: word_nxt = {1'b0, word_q[DATA_W-1:1]};
      default:    word_nxt = word_q;
    endcase
  end

  always_ff @(posedge stb_n or posedge rst) begin
    if (rst) word_q <= '0;
    else     word_q <= word_nxt;
  end

  assign word = word_q;
endmodule

// File: rtl/ppfr_bridge.sv
module ppfr_bridge #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              rst,
  input  logic              host_addr_bit,
  input  logic              mode_stb_n,
  input  logic              xfer_stb_n,
  output logic              host_data_bit,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_data
);
  logic [DATA_W-1:0] word_q;

  ppfr_addr_shifter #(.ADDR_W(ADDR_W)) u_addr (
    .rst    (rst),
    .stb_n  (mode_stb_n),
    .bit_in (host_addr_bit),
    .addr   (flash_addr)
  );

  ppfr_word_shifter #(.DATA_W(DATA_W)) u_word (
    .rst        (rst),
    .stb_n      (xfer_stb_n),
    .mode_level (mode_stb_n),
    .par_in     (flash_data),
    .word       (word_q)
  );

  assign host_data_bit = word_q[0];
endmodule

// File: rtl/ppfr_bridge_chk.sv
module ppfr_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              rst,
  input logic              host_addr_bit,
  input logic              mode_stb_n,
  input logic              xfer_stb_n,
  input logic              host_data_bit,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_data,
  input logic [DATA_W-1:0] word
);
  // Set once a strobe edge has happened since the last reset,
  // so that $past always refers to post-reset values.
  logic xfer_seen_q;
  logic mode_seen_q;

  always_ff @(posedge xfer_stb_n or posedge rst) begin
    if (rst) xfer_seen_q <= 1'b0;
    else     xfer_seen_q <= 1'b1;
  end

  always_ff @(posedge mode_stb_n or posedge rst) begin
    if (rst) mode_seen_q <= 1'b0;
    else     mode_seen_q <= 1'b1;
  end

  p_addr_shift_r1: assert property (@(posedge mode_stb_n) disable iff (rst)
    mode_seen_q |-> flash_addr == {$past(flash_addr[ADDR_W-2:0]), $past(host_addr_bit)});

  p_load_r3: assert property (@(posedge xfer_stb_n) disable iff (rst)
    (xfer_seen_q && $past(mode_stb_n)) |-> word == $past(flash_data));

  p_shift_r4: assert property (@(posedge xfer_stb_n) disable iff (rst)
    (xfer_seen_q && !$past(mode_stb_n)) |-> word[DATA_W-2:0] == $past(word[DATA_W-1:1]));

  p_msb_zero_r5: assert property (@(posedge xfer_stb_n) disable iff (rst)
    (xfer_seen_q && !$past(mode_stb_n)) |-> word[DATA_W-1] == 1'b0);

  p_out_bit_r6: assert property (@(posedge xfer_stb_n) disable iff (rst)
    (xfer_seen_q && !$past(mode_stb_n)) |-> host_data_bit == $past(word[1]));

endmodule

bind ppfr_bridge ppfr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .rst           (rst),
  .host_addr_bit (host_addr_bit),
  .mode_stb_n    (mode_stb_n),
  .xfer_stb_n    (xfer_stb_n),
  .host_data_bit (host_data_bit),
  .flash_addr    (flash_addr),
  .flash_data    (flash_data),
  .word          (word_q)
);

// File: tb/ppfr_bridge_bench.sv
module ppfr_bridge_bench;
  localparam int ADDR_W   = 20;
  localparam int DATA_W   = 16;
  localparam int T_STB    = 20;
  localparam int HALF     = T_STB / 2;
  localparam int WD_LIMIT = 150000;

  logic              rst = 1'b1;
  logic              host_addr_bit = 1'b0;
  logic              mode_stb_n = 1'b1;
  logic              xfer_stb_n = 1'b1;
  logic              host_data_bit;
  logic [ADDR_W-1:0] flash_addr;
  logic [DATA_W-1:0] flash_data;

  logic              use_forced = 1'b0;
  logic [DATA_W-1:0] forced = '0;
  logic [ADDR_W-1:0] exp_addr = '0;
  int                n_run = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  // Flash contents model: a fixed scramble of the address.
  function automatic logic [DATA_W-1:0] flash_fn(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = ({12'h0, a} * 32'h0000_9E37) ^ ({12'h0, a} >> 5) ^ 32'h0000_5A3C;
    return t[DATA_W-1:0];
  endfunction

  assign flash_data = use_forced ? forced : flash_fn(flash_addr);

  ppfr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ppfr_bridge (
    .rst           (rst),
    .host_addr_bit (host_addr_bit),
    .mode_stb_n    (mode_stb_n),
    .xfer_stb_n    (xfer_stb_n),
    .host_data_bit (host_data_bit),
    .flash_addr    (flash_addr),
    .flash_data    (flash_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mode_edge(input logic b);
    host_addr_bit = b;
    mode_stb_n = 1'b0;
    #HALF;
    mode_stb_n = 1'b1;
    exp_addr = {exp_addr[ADDR_W-2:0], b};
    #HALF;
  endtask

  task automatic pulse_xfer();
    xfer_stb_n = 1'b0;
    #HALF;
    xfer_stb_n = 1'b1;
    #HALF;
  endtask

  task automatic read_word(input logic [ADDR_W-1:0] a, input logic force_en,
                           input logic [DATA_W-1:0] fv, input logic scramble);
    logic [DATA_W-1:0] exp_w;
    logic [DATA_W-1:0] got;
    use_forced = force_en;
    forced = fv;
    for (int i = ADDR_W - 1; i >= 0; i--) mode_edge(a[i]);
    check(flash_addr == a && flash_addr == exp_addr, "R1", 32'(flash_addr), 32'(a));
    exp_w = force_en ? fv : flash_fn(a);
    pulse_xfer();
    check(flash_addr == a, "R2", 32'(flash_addr), 32'(a));
    check(host_data_bit == exp_w[0], "R3", 32'(host_data_bit), 32'(exp_w[0]));
    mode_stb_n = 1'b0;
    #HALF;
    got = '0;
    for (int i = 0; i < DATA_W; i++) begin
      got[i] = host_data_bit;
      if (scramble && i == DATA_W / 2) forced = ~forced;   // R4: must be ignored
      pulse_xfer();
    end
    check(got == exp_w, scramble ? "R4" : "R6", 32'(got), 32'(exp_w));
    check(host_data_bit == 1'b0, "R5", 32'(host_data_bit), 32'h0);
    check(flash_addr == a, "R2", 32'(flash_addr), 32'(a));
    mode_edge(1'($urandom_range(0, 1)));
  endtask

  initial begin
    #(T_STB * WD_LIMIT);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7113));
    #(T_STB);
    check(host_data_bit == 1'b0, "R7", 32'(host_data_bit), 32'h0);
    check(flash_addr == '0, "R7", 32'(flash_addr), 32'h0);
    rst = 1'b0;
    #(T_STB);

    // Directed words: isolated, adjacent, extreme bit patterns.
    read_word(20'hA5C3E, 1'b1, 16'hACCE, 1'b0);
    read_word(20'h00001, 1'b1, 16'h0090, 1'b0);
    read_word(20'hFFFFF, 1'b1, 16'hFFFF, 1'b0);
    read_word(20'h80000, 1'b1, 16'h0001, 1'b0);
    read_word(20'h12345, 1'b1, 16'h8000, 1'b0);
    read_word(20'h0F0F0, 1'b1, 16'h5555, 1'b0);
    read_word(20'h3C3C3, 1'b1, 16'hAAAA, 1'b0);
    read_word(20'h77777, 1'b1, 16'h0660, 1'b0);
    // R4: flash data changes mid shift-out must not disturb the word.
    read_word(20'h24680, 1'b1, 16'hC3A1, 1'b1);
    read_word(20'h13579, 1'b1, 16'h0001, 1'b1);

    // Random addresses from the flash model.
    for (int k = 0; k < 30; k++)
      read_word(20'($urandom), 1'b0, '0, 1'b0);

    // R7: reset in the middle of a read clears both registers.
    for (int i = ADDR_W - 1; i >= 0; i--) mode_edge(1'b1);
    use_forced = 1'b1;
    forced = 16'hFFFF;
    pulse_xfer();
    mode_stb_n = 1'b0;
    #HALF;
    for (int i = 0; i < 3; i++) pulse_xfer();
    rst = 1'b1;
    #HALF;
    check(host_data_bit == 1'b0, "R7", 32'(host_data_bit), 32'h0);
    check(flash_addr == '0, "R7", 32'(flash_addr), 32'h0);
    rst = 1'b0;
    exp_addr = '0;
    #HALF;
    pulse_xfer();
    check(host_data_bit == 1'b0, "R7", 32'(host_data_bit), 32'h0);
    mode_edge(1'b1);
    check(flash_addr == exp_addr, "R1", 32'(flash_addr), 32'(exp_addr));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule